// File: doc/BRIEF.md
# Multi-Lane Serial Peripheral Controller

This block is the controller end of an SPI link that moves one character per transfer. A local configuration register selects the clock idle level, the edge on which data is sampled, the character length (1 to 16 bits), and how many data lines carry the character: one, two or four. It also selects whether a single-lane link uses separate out and in lines or one shared line, and sets the active level of each of three target-select outputs. A transfer uses the configuration that is in force when the transfer starts.

The host writes the configuration word, places a character on `tx_char`, picks a target and a direction, and pulses `start`. The block then asserts the chosen select, runs the serial clock for as many cycles as the character needs on the chosen lane count, and shifts data out and in, most significant bits first. When it finishes it releases the select, pulses `done` for one cycle and presents the received character right-aligned on `rx_char`. A divider parameter sets the serial half period in system clocks.

Top module: `spi_lane_ctrl`

## Requirements
- R1: After reset the configuration is clock idle low, sample on rising edge, single lane, separate in and out lines, 16-bit character, every select active low; `sclk`=0, `busy`=0, `done`=0, `sd_oe`=0, `ts_o`=3'b111, `rx_char`=0.
- R2: The configuration word is {ts_pol[2:0] (bits 11:9), shared (bit 8), lanes[1:0] (bits 7:6), len_code[3:0] (bits 5:2), cpha (bit 1), cpol (bit 0)}; len_code 1..15 gives that many bits and 0 gives 16.
- R3: While idle `sclk` rests at cpol; a transfer toggles `sclk` 2*ceil(len/k) times, one toggle every HALF_CYC clocks, where k is the lane count.
- R4: With cpha=0 data is sampled on rising `sclk` edges and with cpha=1 on falling edges; outgoing data changes only on the other edge, and the first piece of data is on the lines before the first edge.
- R5: Single lane with shared=0: data leaves on `sd_o[0]` and arrives on `sd_i[1]` in the same transfer, most significant bit first; `sd_oe[0]`=1 throughout the transfer for either direction.
- R6: Single lane with shared=1: data arrives on `sd_i[0]`; with `rd_dir`=1 `sd_oe` is 0 for the whole transfer, with `rd_dir`=0 `sd_oe`=4'b0001.
- R7: lanes code 1 uses two lines with the higher bit of each pair on line 1; code 2 uses four lines with the highest bit on line 3; code 3 acts as code 0. A character that does not fill the last clock is padded and the unused received bits are dropped.
- R8: `tgt_sel` n (0..2) drives `ts_o[n]` to `ts_pol[n]` while every other select sits at its inactive level `~ts_pol`; `tgt_sel`=3 asserts none. The select is asserted HALF_CYC clocks before the first `sclk` edge and released HALF_CYC clocks after the last.
- R9: `busy` rises in the cycle after a `start` is accepted; `done` is a single-cycle pulse HALF_CYC*(2*ceil(len/k)+1) clocks after the accepting edge, with `busy` falling at the same edge; `rx_char` then holds the received character right-aligned with the upper bits zero.
- R10: A `start` while `busy` is ignored and produces no extra transfer; a configuration write during a transfer does not alter it and takes effect afterwards.
- R11: In multi-lane or shared modes with `rd_dir`=0 the used lanes have `sd_oe` set during the transfer; `sd_oe` is 0 whenever the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 12 | Configuration word |
| start | input | 1 | Transfer request, accepted when idle |
| rd_dir | input | 1 | 1 releases shared data lines for a read |
| tgt_sel | input | 2 | Target index; 3 selects none |
| tx_char | input | 16 | Character to send, right-aligned |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| rx_char | output | 16 | Received character, right-aligned |
| sclk | output | 1 | Serial clock |
| sd_o | output | 4 | Data line outputs |
| sd_oe | output | 4 | Data line output enables |
| sd_i | input | 4 | Data line inputs |
| ts_o | output | 3 | Target-select outputs |

## Verification
`busy`, the select level and the output enables are due one clock after the edge that accepts `start`, so the bench reads them at the falling clock edge that follows. Every serial clock edge falls a whole multiple of HALF_CYC clocks after that edge, and a bench peripheral model reacts on the falling system-clock edge after each toggle, so the block's next sampling edge always finds settled data. The result check fires on the sampling point where `done` is seen and compares the elapsed clock count with HALF_CYC*(2*ceil(len/k)+1), together with the received and captured characters, the toggle count, and that `done` is low one clock later.

// File: rtl/spi_lane_pkg.sv
package spi_lane_pkg;
  localparam int CHAR_W = 16;
  localparam int LEN_W  = $clog2(CHAR_W);
  localparam int TS_N   = 3;
  localparam int TGT_W  = $clog2(TS_N + 1);
  localparam int LANE_N = 4;

  typedef enum logic [1:0] {
    LW_ONE  = 2'd0,
    LW_TWO  = 2'd1,
    LW_FOUR = 2'd2,
    LW_RSVD = 2'd3
  } lane_w_e;

  typedef struct packed {
    logic [TS_N-1:0]  ts_pol;
    logic             shared;
    lane_w_e          lanes;
    logic [LEN_W-1:0] len_code;
    logic             cpha;
    logic             cpol;
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LEAD,
    ST_XFER,
    ST_TRAIL
  } phase_e;
endpackage

// File: rtl/spi_lane_timer.sv
module spi_lane_timer
  import spi_lane_pkg::*;
#(
  parameter int HALF_CYC = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           go,
  input  logic           idle_pol,
  input  logic [LEN_W:0] n_chunks,
  output logic           busy,
  output logic           sclk,
  output logic           done,
  output logic           edge_now,
  output logic           edge_rise,
  output logic           finish_now
);
  localparam int DIV_W = $clog2(HALF_CYC + 1);

  phase_e           st_q;
  logic [DIV_W-1:0] div_q;
  logic [LEN_W+1:0] ecnt_q;
  logic [LEN_W+1:0] edge_last;
  logic             sclk_q;
  logic             done_q;
  logic             tick;

  assign tick       = (div_q == DIV_W'(HALF_CYC - 1));
  assign edge_last  = {n_chunks, 1'b0} - (LEN_W + 2)'(1);
  assign edge_now   = tick && ((st_q == ST_LEAD) || (st_q == ST_XFER));
  assign edge_rise  = ~sclk_q;
  assign finish_now = tick && (st_q == ST_TRAIL);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      div_q  <= '0;
      ecnt_q <= '0;
      sclk_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if ((st_q == ST_IDLE) || tick) div_q <= '0;
      else                           div_q <= div_q + 1'b1;
      case (st_q)
        ST_IDLE: begin
          sclk_q <= idle_pol;
          ecnt_q <= '0;
          if (go) st_q <= ST_LEAD;
        end
        ST_LEAD, ST_XFER: begin
          if (tick) begin
            sclk_q <= ~sclk_q;
            ecnt_q <= ecnt_q + 1'b1;
            st_q   <= (ecnt_q == edge_last) ? ST_TRAIL : ST_XFER;
          end
        end
        ST_TRAIL: begin
          if (tick) begin
            st_q   <= ST_IDLE;
            done_q <= 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy = (st_q != ST_IDLE);
  assign sclk = sclk_q;
  assign done = done_q;
endmodule

// File: rtl/spi_lane_shifter.sv
module spi_lane_shifter
  import spi_lane_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [CHAR_W-1:0] tx_char,
  input  logic [LEN_W:0]    len_bits,
  input  logic [LEN_W:0]    pad,
  input  logic [1:0]        k_log,
  input  logic              four_wire,
  input  logic              cpha,
  input  logic              edge_now,
  input  logic              edge_rise,
  input  logic              finish,
  input  logic [LANE_N-1:0] sd_i,
  output logic [LANE_N-1:0] sd_o,
  output logic [CHAR_W-1:0] rx_char
);
  logic [CHAR_W-1:0] tx_sr, rx_sr, rx_q;
  logic [LANE_N-1:0] in_ch;
  logic [2:0]        lane_cnt;
  logic              got_q;
  logic              sample_now, shift_now;

  assign lane_cnt   = 3'd1 << k_log;
  assign sample_now = edge_now && (edge_rise == ~cpha);
  assign shift_now  = edge_now && !sample_now && got_q;

  always_comb begin
    case (k_log)
      2'd1: begin
        in_ch = {{(LANE_N-2){1'b0}}, sd_i[1:0]};
        sd_o  = {{(LANE_N-2){1'b0}}, tx_sr[CHAR_W-1 -: 2]};
      end
      2'd2: begin
        in_ch = sd_i;
        sd_o  = tx_sr[CHAR_W-1 -: LANE_N];
      end
      default: begin
        in_ch = {{(LANE_N-1){1'b0}}, (four_wire ? sd_i[1] : sd_i[0])};
        sd_o  = {{(LANE_N-1){1'b0}}, tx_sr[CHAR_W-1]};
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_sr <= '0;
      rx_sr <= '0;
      rx_q  <= '0;
      got_q <= 1'b0;
    end else begin
      if (load) begin
        tx_sr <= tx_char << ((LEN_W + 1)'(CHAR_W) - len_bits);
        rx_sr <= '0;
        got_q <= 1'b0;
      end else if (sample_now) begin
        rx_sr <= (rx_sr << lane_cnt) | CHAR_W'(in_ch);
        got_q <= 1'b1;
      end else if (shift_now) begin
        tx_sr <= tx_sr << lane_cnt;
      end
      if (finish) rx_q <= rx_sr >> pad;
    end
  end

  assign rx_char = rx_q;
endmodule

// File: rtl/spi_lane_select.sv
module spi_lane_select
  import spi_lane_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             finish,
  input  logic [TGT_W-1:0] tgt,
  input  logic [TS_N-1:0]  pol,
  output logic [TS_N-1:0]  ts_o
);
  for (genvar g = 0; g < TS_N; g++) begin : g_sel
    logic act_q;
    always_ff @(posedge clk) begin
      if (rst)         act_q <= 1'b0;
      else if (load)   act_q <= (tgt == TGT_W'(g));
      else if (finish) act_q <= 1'b0;
    end
    assign ts_o[g] = ~(act_q ^ pol[g]);
  end
endmodule

// File: rtl/spi_lane_ctrl.sv
module spi_lane_ctrl
  import spi_lane_pkg::*;
#(
  parameter int HALF_CYC = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              start,
  input  logic              rd_dir,
  input  logic [TGT_W-1:0]  tgt_sel,
  input  logic [CHAR_W-1:0] tx_char,
  output logic              busy,
  output logic              done,
  output logic [CHAR_W-1:0] rx_char,
  output logic              sclk,
  output logic [LANE_N-1:0] sd_o,
  output logic [LANE_N-1:0] sd_oe,
  input  logic [LANE_N-1:0] sd_i,
  output logic [TS_N-1:0]   ts_o
);
  cfg_t              cfg_q, run_q, cur_cfg;
  logic              dir_q, go, busy_w, done_w;
  logic              edge_now, edge_rise, finish_now;
  logic [1:0]        k_log;
  logic [LEN_W:0]    len_bits, n_chunks, pad;
  logic [LEN_W+1:0]  rnd, tot;
  logic              four_wire;
  logic [LANE_N-1:0] lane_mask;

  assign go      = start & ~busy_w;
  assign cur_cfg = busy_w ? run_q : cfg_q;

  always_ff @(posedge clk) begin
    if (rst)         cfg_q <= '0;
    else if (cfg_we) cfg_q <= cfg_t'(cfg_wdata);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= '0;
      dir_q <= 1'b0;
    end else if (go) begin
      run_q <= cfg_q;
      dir_q <= rd_dir;
    end
  end

  always_comb begin
    case (cur_cfg.lanes)
      LW_TWO: begin
        k_log     = 2'd1;
        lane_mask = {{(LANE_N-2){1'b0}}, 2'b11};
      end
      LW_FOUR: begin
        k_log     = 2'd2;
        lane_mask = '1;
      end
      default: begin
        k_log     = 2'd0;
        lane_mask = {{(LANE_N-1){1'b0}}, 1'b1};
      end
    endcase
    len_bits  = (cur_cfg.len_code == '0) ? (LEN_W + 1)'(CHAR_W)
                                         : {1'b0, cur_cfg.len_code};
    rnd       = {1'b0, len_bits} + (LEN_W + 2)'((1 << k_log) - 1);
    n_chunks  = (LEN_W + 1)'(rnd >> k_log);
    tot       = (LEN_W + 2)'(n_chunks) << k_log;
    pad       = (LEN_W + 1)'(tot - {1'b0, len_bits});
    four_wire = (k_log == 2'd0) && !cur_cfg.shared;
  end

  always_comb begin
    if (!busy_w)        sd_oe = '0;
    else if (four_wire) sd_oe = {{(LANE_N-1){1'b0}}, 1'b1};
    else if (dir_q)     sd_oe = '0;
    else                sd_oe = lane_mask;
  end

  spi_lane_timer #(.HALF_CYC(HALF_CYC)) timer_i (
    .clk        (clk),
    .rst        (rst),
    .go         (go),
    .idle_pol   (cur_cfg.cpol),
    .n_chunks   (n_chunks),
    .busy       (busy_w),
    .sclk       (sclk),
    .done       (done_w),
    .edge_now   (edge_now),
    .edge_rise  (edge_rise),
    .finish_now (finish_now)
  );

  spi_lane_shifter shifter_i (
    .clk       (clk),
    .rst       (rst),
    .load      (go),
    .tx_char   (tx_char),
    .len_bits  (len_bits),
    .pad       (pad),
    .k_log     (k_log),
    .four_wire (four_wire),
    .cpha      (cur_cfg.cpha),
    .edge_now  (edge_now),
    .edge_rise (edge_rise),
    .finish    (finish_now),
    .sd_i      (sd_i),
    .sd_o      (sd_o),
    .rx_char   (rx_char)
  );

  spi_lane_select select_i (
    .clk    (clk),
    .rst    (rst),
    .load   (go),
    .finish (finish_now),
    .tgt    (tgt_sel),
    .pol    (cur_cfg.ts_pol),
    .ts_o   (ts_o)
  );

  assign busy = busy_w;
  assign done = done_w;
endmodule

// File: rtl/spi_lane_ctrl_chk.sv
module spi_lane_ctrl_chk
  import spi_lane_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              cfg_we,
  input logic              busy,
  input logic              done,
  input logic              sclk,
  input logic [LANE_N-1:0] sd_oe,
  input logic [TS_N-1:0]   ts_o,
  input logic              idle_cpol,
  input logic [TS_N-1:0]   idle_pol,
  input logic [TS_N-1:0]   run_pol
);
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R9

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done); // R9

  AST_BUSY_NEEDS_START: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start)); // R9

  AST_IDLE_OE_OFF: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (sd_oe == '0)); // R11

  AST_IDLE_SCLK_LEVEL: assert property (@(posedge clk) disable iff (rst)
    (!busy && $past(!busy) && !$past(cfg_we)) |-> (sclk == idle_cpol)); // R3

  AST_SEL_AT_MOST_ONE: assert property (@(posedge clk) disable iff (rst)
    busy |-> $onehot0(~(ts_o ^ run_pol))); // R8

  AST_SEL_IDLE_LEVEL: assert property (@(posedge clk) disable iff (rst)
    (!busy && !$past(cfg_we)) |-> (ts_o == ~idle_pol)); // R8
endmodule

bind spi_lane_ctrl spi_lane_ctrl_chk chk_i (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .cfg_we    (cfg_we),
  .busy      (busy),
  .done      (done),
  .sclk      (sclk),
  .sd_oe     (sd_oe),
  .ts_o      (ts_o),
  .idle_cpol (cfg_q.cpol),
  .idle_pol  (cfg_q.ts_pol),
  .run_pol   (run_q.ts_pol)
);

// File: tb/spi_lane_ctrl_tb_top.sv
module spi_lane_ctrl_tb_top;
  import spi_lane_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 2;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cfg_we = 1'b0;
  logic [CFG_W-1:0]  cfg_wdata = '0;
  logic              start = 1'b0;
  logic              rd_dir = 1'b0;
  logic [TGT_W-1:0]  tgt_sel = '0;
  logic [CHAR_W-1:0] tx_char = '0;
  logic              busy, done, sclk;
  logic [CHAR_W-1:0] rx_char;
  logic [LANE_N-1:0] sd_o, sd_oe;
  logic [LANE_N-1:0] sd_i = '0;
  logic [TS_N-1:0]   ts_o;

  spi_lane_ctrl #(.HALF_CYC(HALF)) dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .start(start), .rd_dir(rd_dir), .tgt_sel(tgt_sel), .tx_char(tx_char),
    .busy(busy), .done(done), .rx_char(rx_char), .sclk(sclk),
    .sd_o(sd_o), .sd_oe(sd_oe), .sd_i(sd_i), .ts_o(ts_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int     n_chk = 0;
  int     n_bad = 0;
  longint cyc = 0;
  longint t_start = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    logic [15:0] rx;
    logic [15:0] tx;
    bit          chk_tx;
    int          lat;
    int          len;
    int          k;
    int          nc;
    string       tag;
  } exp_t;
  exp_t sb_q[$];

  // peripheral model state
  int          s_k = 1;
  bit          s_four = 1'b1;
  bit          s_cpha = 1'b0;
  bit          s_got = 1'b0;
  bit          s_on = 1'b0;
  logic [15:0] s_sr = '0;
  logic [15:0] s_cap = '0;
  logic        s_prev = 1'b0;
  int          s_edges = 0;
  bit          done_seen = 1'b0;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  function automatic logic [3:0] s_lanes_out();
    case (s_k)
      4:       return s_sr[15:12];
      2:       return {2'b00, s_sr[15:14]};
      default: return s_four ? {2'b00, s_sr[15], 1'b0} : {3'b000, s_sr[15]};
    endcase
  endfunction

  function automatic logic [15:0] len_mask(int len);
    return (len == 16) ? 16'hFFFF : ((16'h1 << len) - 16'h1);
  endfunction

  // peripheral model and scoreboard monitor
  always @(negedge clk) begin
    if (s_on && (sclk !== s_prev)) begin
      s_edges++;
      if (sclk == ~s_cpha) begin
        s_got = 1'b1;
        case (s_k)
          4:       s_cap = {s_cap[11:0], sd_o};
          2:       s_cap = {s_cap[13:0], sd_o[1:0]};
          default: s_cap = {s_cap[14:0], sd_o[0]};
        endcase
      end else if (s_got) begin
        s_sr = s_sr << s_k;
        sd_i = s_lanes_out();
      end
    end
    s_prev = sclk;
    if (done_seen) check("R9 done lasts one cycle", {31'd0, done}, 32'd0);
    done_seen = (done === 1'b1);
    if (done === 1'b1) begin
      if (sb_q.size() == 0) begin
        n_chk++;
        n_bad++;
        $display("FAIL R10 unexpected done actual=1 expected=0");
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        check({"R9 rx char ", e.tag}, {16'd0, rx_char}, {16'd0, e.rx});
        check({"R9 latency ", e.tag}, 32'(cyc - t_start), 32'(e.lat));
        check({"R3 edge count ", e.tag}, 32'(s_edges), 32'(2 * e.nc));
        if (e.chk_tx)
          check({"R5 tx char ", e.tag},
                {16'd0, s_cap >> (e.nc * e.k - e.len)}, {16'd0, e.tx});
      end
    end
  end

  task automatic xfer(string tag, bit wr_cfg, logic cpol, logic cpha,
                      logic [3:0] lcode, logic [1:0] lw, logic shared,
                      logic [2:0] pol, logic [1:0] tgt, logic dir,
                      logic [15:0] tx, logic [15:0] sl, bit poke);
    int   len, k, nc;
    exp_t e;
    logic [2:0] ts_exp;
    logic [3:0] oe_exp;
    bit   four;
    len  = (lcode == 4'd0) ? 16 : int'(lcode);
    k    = (lw == 2'd1) ? 2 : (lw == 2'd2) ? 4 : 1;
    nc   = (len + k - 1) / k;
    four = (k == 1) && !shared;
    if (wr_cfg) begin
      @(negedge clk);
      cfg_we    = 1'b1;
      cfg_wdata = {pol, shared, lw, lcode, cpha, cpol};
      @(negedge clk);
      cfg_we = 1'b0;
    end
    @(negedge clk);
    check({"R3 idle sclk ", tag}, {31'd0, sclk}, {31'd0, cpol});
    check({"R8 idle select ", tag}, {29'd0, ts_o}, {29'd0, ~pol});
    s_k = k; s_four = four; s_cpha = cpha;
    s_sr = sl << (16 - len); s_cap = '0; s_got = 1'b0; s_edges = 0;
    s_prev = sclk; sd_i = s_lanes_out(); s_on = 1'b1;
    e.rx = sl & len_mask(len); e.tx = tx & len_mask(len);
    e.chk_tx = four || !dir; e.lat = HALF * (2 * nc + 1);
    e.len = len; e.k = k; e.nc = nc; e.tag = tag;
    sb_q.push_back(e);
    tx_char = tx; rd_dir = dir; tgt_sel = tgt; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    t_start = cyc;
    for (int n = 0; n < 3; n++) ts_exp[n] = (tgt == 2'(n)) ? pol[n] : ~pol[n];
    if (four)     oe_exp = 4'b0001;
    else if (dir) oe_exp = 4'b0000;
    else          oe_exp = (k == 4) ? 4'b1111 : (k == 2) ? 4'b0011 : 4'b0001;
    check({"R9 busy after start ", tag}, {31'd0, busy}, 32'd1);
    check({"R8 select before first edge ", tag}, {28'd0, sclk, ts_o}, {28'd0, cpol, ts_exp});
    check({"R11 R6 output enables ", tag}, {28'd0, sd_oe}, {28'd0, oe_exp});
    if (poke) begin
      repeat (3) @(negedge clk);
      start = 1'b1; tx_char = ~tx; cfg_we = 1'b1;
      cfg_wdata = {pol, shared, lw, 4'd3, cpha, ~cpol};
      @(negedge clk);
      start = 1'b0; cfg_we = 1'b0;
    end
    while (busy === 1'b1) @(negedge clk);
    s_on = 1'b0;
    check({"R11 idle oe ", tag}, {28'd0, sd_oe}, 32'd0);
    if (poke) begin
      repeat (2) @(negedge clk);
      check("R10 later config applied", {31'd0, sclk}, {31'd0, ~cpol});
      repeat (HALF * 40) @(negedge clk);
    end
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL R9 watchdog actual=hung expected=finished");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 sclk", {31'd0, sclk}, 32'd0);
    check("R1 busy", {31'd0, busy}, 32'd0);
    check("R1 done", {31'd0, done}, 32'd0);
    check("R1 oe", {28'd0, sd_oe}, 32'd0);
    check("R1 select", {29'd0, ts_o}, 32'd7);
    check("R1 rx", {16'd0, rx_char}, 32'd0);
    // R1 R5 reset configuration: mode 0, 16 bits, separate lines
    xfer("R1 default", 1'b0, 0, 0, 4'd0, 2'd0, 0, 3'b000, 2'd0, 0, 16'hA5C3, 16'h3C96, 0);
    // R4 phase variants, R2 length codes
    xfer("R4 mode1 8b", 1'b1, 0, 1, 4'd8, 2'd0, 0, 3'b000, 2'd1, 0, 16'h005A, 16'hFF81, 0);
    xfer("R3 mode2 10b", 1'b1, 1, 0, 4'd10, 2'd0, 0, 3'b000, 2'd2, 0, 16'h02B7, 16'h0355, 0);
    xfer("R4 mode3 13b", 1'b1, 1, 1, 4'd13, 2'd0, 0, 3'b000, 2'd0, 1, 16'h1ACE, 16'hF0F1, 0);
    xfer("R2 one bit", 1'b1, 0, 0, 4'd1, 2'd0, 0, 3'b000, 2'd0, 0, 16'h0001, 16'hFFFF, 0);
    // R6 shared single line
    xfer("R6 shared read", 1'b1, 0, 0, 4'd9, 2'd0, 1, 3'b000, 2'd1, 1, 16'h0000, 16'h01A3, 0);
    xfer("R6 shared write", 1'b1, 0, 1, 4'd9, 2'd0, 1, 3'b000, 2'd1, 0, 16'h0136, 16'h00C5, 0);
    // R7 multi-lane
    xfer("R7 dual 5b", 1'b1, 0, 0, 4'd5, 2'd1, 0, 3'b000, 2'd0, 0, 16'h0016, 16'h000D, 0);
    xfer("R7 dual read 16b", 1'b1, 1, 1, 4'd0, 2'd1, 1, 3'b000, 2'd0, 1, 16'h0000, 16'hBEEF, 0);
    xfer("R7 quad 12b", 1'b1, 0, 1, 4'd12, 2'd2, 1, 3'b000, 2'd2, 0, 16'h0C3A, 16'h0F0E, 0);
    xfer("R7 quad read 7b", 1'b1, 0, 0, 4'd7, 2'd2, 1, 3'b000, 2'd1, 1, 16'h0000, 16'h1265, 0);
    xfer("R7 reserved width", 1'b1, 0, 0, 4'd6, 2'd3, 0, 3'b000, 2'd0, 0, 16'h0029, 16'h0017, 0);
    // R8 select polarity
    xfer("R8 pol 101 tgt2", 1'b1, 0, 0, 4'd4, 2'd0, 0, 3'b101, 2'd2, 0, 16'h0009, 16'h0006, 0);
    xfer("R8 no target", 1'b1, 0, 0, 4'd4, 2'd0, 0, 3'b011, 2'd3, 0, 16'h0003, 16'h000A, 0);
    // R10 start and config write during a transfer
    xfer("R10 busy start", 1'b1, 0, 0, 4'd11, 2'd0, 0, 3'b000, 2'd0, 0, 16'h0555, 16'h02AA, 1);
    check("R10 queue drained", 32'(sb_q.size()), 32'd0);
    report();
  end
endmodule